// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Flags

This block buffers received serial characters between a UART receive engine and a host read port. Each character is stored with its three error flags. The host always sees the oldest character and the flags that belong to it. The flags of a later character become visible only when that character reaches the read position. When the queue is switched off, it acts as a single holding register of one entry.

The block has two receive interrupts. The data-ready interrupt fires as soon as a character is present, or it waits until the fill level reaches a programmed threshold. The time-out interrupt covers data that stays below the threshold. A small state machine counts bit-period ticks while the queue holds some data but less than the threshold. If no character is written or read for four character times plus twelve bit times, the time-out interrupt rises. A line-status interrupt reports a flagged head character or a lost character. Changing the queue enable empties the store.

The time-out state machine has three states:
- `TO_IDLE`: no count is running.
- `TO_COUNT`: ticks are being counted.
- `TO_FIRED`: the time-out has expired.

Its transitions are:
- IDLE→COUNT: the queue becomes qualifying, meaning queue mode on and 0 < fill < threshold.
- COUNT→COUNT: a restart on an accepted write or read, or the count advancing on a tick.
- COUNT→FIRED: the count reaches its limit.
- FIRED→COUNT: a write or read is accepted.
- COUNT/FIRED→IDLE: the queue stops being qualifying.

Top module: `rx_tag_fifo`

## Requirements
- R1: With `fifo_en`=1, up to DEPTH (64) characters are held. They leave in arrival order, each with its 8-bit data and 3-bit flag field unchanged, and `fill` counts the stored entries.
- R2: `head_data`/`head_tag` show the oldest entry. A read of a non-empty store advances to the next entry at the next clock edge, and the head then shows that entry's flags. When the store is empty, both head outputs are zero.
- R3: With `fifo_en`=0, the capacity is one entry. A second write before a read is dropped, and the held character stays at the head.
- R4: A write that finds the store full, with no read in the same cycle, is dropped. It sets `overrun`, and `fill` stays at the capacity.
- R5: `overrun` stays set until a cycle with `stat_rd`=1. If a drop and `stat_rd` occur in the same cycle, the flag stays set.
- R6: `dr_irq` = `rx_ie` AND condition, where the condition depends on the mode:
  - queue mode: fill ≥ max(`trig_lvl`,1).
  - holding mode: fill ≠ 0.
- R7: The time-out applies when `fifo_en`=1 and 0 < fill < `trig_lvl`. With `bit_tick` held at 1, `to_irq` rises exactly N = 4·(7+`wlen`)+12 clock edges after the last edge at which a character was accepted or read. Here `wlen` 0..3 selects 5..8 data bits. `to_irq` is gated by `rx_ie`.
- R8: An accepted write or read restarts the time-out count. When the store empties or the fill reaches `trig_lvl`, the time-out drops and its count clears.
- R9: `ls_irq` = `ls_ie` AND (head flag field nonzero OR `overrun`).
- R10: A change of `fifo_en` empties the store and resets both pointers at that edge, so `fill` is 0 afterwards. A write in that cycle is dropped.
- R11: A read of an empty store is ignored. When a read and a write coincide on a full store, both take effect and `fill` is unchanged.
- R12: The time-out count advances only on cycles with `bit_tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: 64-entry queue mode; 0: single holding register |
| trig_lvl | input | 7 | Data-ready threshold in queue mode |
| wlen | input | 2 | Data bits per character minus 5 |
| bit_tick | input | 1 | One pulse per bit period |
| rx_ie | input | 1 | Enables data-ready and time-out interrupts |
| ls_ie | input | 1 | Enables line-status interrupt |
| wr_stb | input | 1 | Character strobe from receive engine |
| wr_data | input | 8 | Received character |
| wr_tag | input | 3 | Error flags of received character |
| rd_stb | input | 1 | Host reads head character |
| stat_rd | input | 1 | Host reads status; clears overrun |
| head_data | output | 8 | Oldest character |
| head_tag | output | 3 | Error flags of oldest character |
| fill | output | 7 | Stored entry count |
| overrun | output | 1 | Sticky lost-character flag |
| dr_irq | output | 1 | Data-ready interrupt |
| to_irq | output | 1 | Receive time-out interrupt |
| ls_irq | output | 1 | Line-status interrupt |

## Verification
Writes, reads, flushes and overrun changes take effect at the clock edge that samples the strobe. The head outputs, `fill`, `overrun` and all three interrupts are therefore valid just after that edge, because the interrupts are combinational on registered state and on the enables. The one longer latency is the time-out, which is due exactly N edges after the last accepted write or read. The bench counts edges from that point and samples both the edge before and the edge where the interrupt rises. All strobes are driven and all outputs are sampled 2 ns after a rising edge, so each check falls in a known cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int RXQ_DATA_W = 8;
    localparam int RXQ_TAG_W  = 3;

    typedef struct packed {
        logic [RXQ_TAG_W-1:0]  tag;
        logic [RXQ_DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } to_state_e;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         cap_one,
    input  logic                         wr_stb,
    input  logic [RXQ_DATA_W-1:0]        wr_data,
    input  logic [RXQ_TAG_W-1:0]         wr_tag,
    input  logic                         rd_stb,
    input  logic                         stat_rd,
    output logic [RXQ_DATA_W-1:0]        head_data,
    output logic [RXQ_TAG_W-1:0]         head_tag,
    output logic [$clog2(DEPTH+1)-1:0]   fill,
    output logic                         overrun,
    output logic                         wr_acc,
    output logic                         rd_acc
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t         mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     cap;
    logic              full;
    logic              drop;
    rx_entry_t         head;

    assign cap    = cap_one ? CW'(1) : CW'(DEPTH);
    assign full   = (cnt >= cap);
    assign rd_acc = rd_stb && (cnt != '0) && !flush;
    assign wr_acc = wr_stb && !flush && (!full || rd_acc);
    assign drop   = wr_stb && !flush && full && !rd_acc;

    always_ff @(posedge clk) begin
        if (wr_acc) begin
            mem[wr_ptr] <= '{tag: wr_tag, data: wr_data};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_acc) wr_ptr <= wr_ptr + 1'b1;
            if (rd_acc) rd_ptr <= rd_ptr + 1'b1;
            unique case ({wr_acc, rd_acc})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (drop) begin
            overrun <= 1'b1;
        end else if (stat_rd) begin
            overrun <= 1'b0;
        end
    end

    always_comb begin
        if (cnt != '0) head = mem[rd_ptr];
        else           head = '0;
    end

    assign head_data = head.data;
    assign head_tag  = head.tag;
    assign fill      = cnt;

endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout
    import rxq_pkg::*;
#(
    parameter int CHARS     = 4,
    parameter int MIN_BITS  = 5,
    parameter int FRAME_BITS = 2,
    parameter int EXTRA_BITS = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       qual,
    input  logic       act,
    input  logic       tick,
    input  logic [1:0] wlen,
    output logic       fired
);
    localparam int MAX_LIM = CHARS * (MIN_BITS + FRAME_BITS + 3) + EXTRA_BITS;
    localparam int TCW     = $clog2(MAX_LIM + 1);

    to_state_e       st, st_nx;
    logic [TCW-1:0]  cnt, cnt_nx;
    logic [TCW-1:0]  lim;

    assign lim = TCW'(CHARS * (MIN_BITS + FRAME_BITS + int'(wlen)) + EXTRA_BITS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= TO_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            TO_IDLE: begin
                cnt_nx = '0;
                if (qual) begin
                    st_nx  = TO_COUNT;
                    cnt_nx = (tick && !act) ? TCW'(1) : '0;
                end
            end
            TO_COUNT: begin
                if (!qual) begin
                    st_nx  = TO_IDLE;
                    cnt_nx = '0;
                end else if (act) begin
                    cnt_nx = '0;
                end else if (tick) begin
                    if (cnt == lim - 1'b1) begin
                        st_nx  = TO_FIRED;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            TO_FIRED: begin
                cnt_nx = '0;
                if (!qual)     st_nx = TO_IDLE;
                else if (act)  st_nx = TO_COUNT;
            end
            default: begin
                st_nx  = TO_IDLE;
                cnt_nx = '0;
            end
        endcase
    end

    always_comb begin
        fired = (st == TO_FIRED);
    end

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fifo_en,
    input  logic [$clog2(DEPTH+1)-1:0]  trig_lvl,
    input  logic [1:0]                  wlen,
    input  logic                        bit_tick,
    input  logic                        rx_ie,
    input  logic                        ls_ie,
    input  logic                        wr_stb,
    input  logic [RXQ_DATA_W-1:0]       wr_data,
    input  logic [RXQ_TAG_W-1:0]        wr_tag,
    input  logic                        rd_stb,
    input  logic                        stat_rd,
    output logic [RXQ_DATA_W-1:0]       head_data,
    output logic [RXQ_TAG_W-1:0]        head_tag,
    output logic [$clog2(DEPTH+1)-1:0]  fill,
    output logic                        overrun,
    output logic                        dr_irq,
    output logic                        to_irq,
    output logic                        ls_irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic           en_q;
    logic           flush;
    logic           wr_acc;
    logic           rd_acc;
    logic           qual;
    logic           fired;
    logic [CW-1:0]  trig_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fifo_en;
    end

    assign flush    = (fifo_en != en_q);
    assign trig_eff = (trig_lvl == '0) ? CW'(1) : trig_lvl;

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .cap_one   (!fifo_en),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .wr_tag    (wr_tag),
        .rd_stb    (rd_stb),
        .stat_rd   (stat_rd),
        .head_data (head_data),
        .head_tag  (head_tag),
        .fill      (fill),
        .overrun   (overrun),
        .wr_acc    (wr_acc),
        .rd_acc    (rd_acc)
    );

    assign qual = fifo_en && (fill != '0) && (fill < trig_eff);

    rxq_timeout u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .qual  (qual),
        .act   (wr_acc || rd_acc),
        .tick  (bit_tick),
        .wlen  (wlen),
        .fired (fired)
    );

    always_comb begin
        if (fifo_en) dr_irq = rx_ie && (fill >= trig_eff);
        else         dr_irq = rx_ie && (fill != '0);
        to_irq = rx_ie && fired;
        ls_irq = ls_ie && ((head_tag != '0) || overrun);
    end

endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
    parameter int DEPTH = 64
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        fifo_en,
    input logic [$clog2(DEPTH+1)-1:0]  trig_lvl,
    input logic                        rx_ie,
    input logic                        wr_stb,
    input logic                        rd_stb,
    input logic                        stat_rd,
    input logic [$clog2(DEPTH+1)-1:0]  fill,
    input logic                        overrun,
    input logic                        dr_irq,
    input logic                        to_irq,
    input logic                        ls_irq
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= ($clog2(DEPTH+1))'(DEPTH)); // R1

    AST_HOLD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && $stable(fifo_en)) |=> (fill <= 1 || !$stable(fifo_en))); // R3

    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && fill != 0 && $stable(fifo_en)) |=> fill == $past(fill) - 1'b1); // R2

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !stat_rd) |=> overrun); // R5

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ie |-> (!dr_irq && !to_irq)); // R6

    AST_TO_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        to_irq |-> (fifo_en && fill != 0 && fill < trig_lvl)); // R7

    AST_LS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == 0 && !overrun) |-> !ls_irq); // R9

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fifo_en) |=> fill == 0); // R10

endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .trig_lvl (trig_lvl),
    .rx_ie    (rx_ie),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .stat_rd  (stat_rd),
    .fill     (fill),
    .overrun  (overrun),
    .dr_irq   (dr_irq),
    .to_irq   (to_irq),
    .ls_irq   (ls_irq)
);

// File: tb/rx_tag_fifo_tb.sv
module rx_tag_fifo_tb;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic [6:0] trig_lvl = 7'd64;
    logic [1:0] wlen = 2'd0;
    logic       bit_tick = 1'b0;
    logic       rx_ie = 1'b1;
    logic       ls_ie = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [2:0] wr_tag = 3'd0;
    logic       rd_stb = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] head_data;
    logic [2:0] head_tag;
    logic [6:0] fill;
    logic       overrun, dr_irq, to_irq, ls_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rx_tag_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_lvl(trig_lvl),
        .wlen(wlen), .bit_tick(bit_tick), .rx_ie(rx_ie), .ls_ie(ls_ie),
        .wr_stb(wr_stb), .wr_data(wr_data), .wr_tag(wr_tag), .rd_stb(rd_stb),
        .stat_rd(stat_rd), .head_data(head_data), .head_tag(head_tag),
        .fill(fill), .overrun(overrun), .dr_irq(dr_irq), .to_irq(to_irq),
        .ls_irq(ls_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic push(input int d, input int t);
        wr_stb = 1'b1; wr_data = 8'(d); wr_tag = 3'(t);
        step();
        wr_stb = 1'b0;
    endtask

    task automatic pop();
        rd_stb = 1'b1;
        step();
        rd_stb = 1'b0;
    endtask

    function automatic int dval(input int i);
        return (i * 37 + 11) % 256;
    endfunction

    function automatic int tlim(input int w);
        return 4 * (7 + w) + 12;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R2 reset fill", int'(fill), 0);
        chk("R5 reset overrun", int'(overrun), 0);
        chk("R6 reset dr_irq", int'(dr_irq), 0);
        chk("R7 reset to_irq", int'(to_irq), 0);
        chk("R2 reset head_tag", int'(head_tag), 0);

        // R1 fill sweep in queue mode, threshold 64
        fifo_en = 1'b1; step();
        for (int i = 0; i < DEPTH; i++) begin
            push(dval(i), i % 8);
            chk("R1 fill", int'(fill), i + 1);
            chk("R6 dr at threshold 64", int'(dr_irq), (i + 1 >= 64) ? 1 : 0);
        end
        // R4 drop on full
        push(8'hAA, 5);
        chk("R4 fill held", int'(fill), 64);
        chk("R4 overrun set", int'(overrun), 1);
        chk("R9 ls on overrun", int'(ls_irq), 1);
        step(); step();
        chk("R5 overrun sticky", int'(overrun), 1);
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
        chk("R5 overrun cleared", int'(overrun), 0);
        // R11 simultaneous read and write on full
        rd_stb = 1'b1; wr_stb = 1'b1; wr_data = 8'h55; wr_tag = 3'd1;
        step();
        rd_stb = 1'b0; wr_stb = 1'b0;
        chk("R11 fill unchanged", int'(fill), 64);
        chk("R11 no overrun", int'(overrun), 0);
        // R1/R2 drain in order
        for (int i = 1; i < DEPTH; i++) begin
            chk("R1 head data", int'(head_data), dval(i));
            chk("R2 head tag", int'(head_tag), i % 8);
            chk("R9 ls follows tag", int'(ls_irq), (i % 8 != 0) ? 1 : 0);
            pop();
        end
        chk("R1 last data", int'(head_data), 8'h55);
        chk("R2 last tag", int'(head_tag), 1);
        pop();
        chk("R2 empty fill", int'(fill), 0);
        chk("R2 empty head data", int'(head_data), 0);
        chk("R2 empty head tag", int'(head_tag), 0);
        pop();
        chk("R11 read of empty ignored", int'(fill), 0);

        // R6 threshold sweep
        for (int k = 0; k < 4; k++) begin
            int tl;
            tl = (k == 0) ? 1 : (k == 1) ? 4 : (k == 2) ? 8 : 14;
            trig_lvl = 7'(tl);
            step();
            for (int n = 1; n <= tl + 1; n++) begin
                push(n, 0);
                chk("R6 dr vs threshold", int'(dr_irq), (n >= tl) ? 1 : 0);
            end
            rx_ie = 1'b0; #1;
            chk("R6 dr gated", int'(dr_irq), 0);
            rx_ie = 1'b1;
            for (int n = 0; n <= tl; n++) pop();
            chk("R6 drained", int'(fill), 0);
        end

        // R3 holding mode
        fifo_en = 1'b0; step();
        chk("R10 flush on mode change", int'(fill), 0);
        push(8'h3C, 2);
        chk("R3 holding fill", int'(fill), 1);
        chk("R6 holding dr", int'(dr_irq), 1);
        push(8'hC3, 4);
        chk("R3 second write dropped", int'(fill), 1);
        chk("R3 head kept", int'(head_data), 8'h3C);
        chk("R4 holding overrun", int'(overrun), 1);
        // R5 set wins over clear
        wr_stb = 1'b1; stat_rd = 1'b1; step(); wr_stb = 1'b0; stat_rd = 1'b0;
        chk("R5 set beats clear", int'(overrun), 1);
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
        pop();
        chk("R3 holding empty", int'(fill), 0);

        // R10 flush with write in same cycle
        fifo_en = 1'b1; step();
        push(1, 0); push(2, 0); push(3, 0);
        chk("R10 pre-flush fill", int'(fill), 3);
        fifo_en = 1'b0;
        push(4, 0);
        chk("R10 flushed, write dropped", int'(fill), 0);
        fifo_en = 1'b1; step();

        // R7 time-out sweep over word lengths
        trig_lvl = 7'd8; bit_tick = 1'b1;
        for (int w = 0; w < 4; w++) begin
            wlen = 2'(w);
            push(w, 0);
            for (int e = 1; e <= tlim(w); e++) begin
                step();
                if (e == tlim(w) - 1) chk("R7 not yet", int'(to_irq), 0);
                if (e == tlim(w))     chk("R7 fires at N", int'(to_irq), 1);
            end
            rx_ie = 1'b0; #1;
            chk("R7 gated", int'(to_irq), 0);
            rx_ie = 1'b1; #1;
            pop();
            chk("R8 cleared on empty", int'(to_irq), 0);
        end

        // R8 restart on write and on read
        wlen = 2'd0;
        push(9, 0);
        repeat (30) step();
        push(10, 0);
        repeat (tlim(0) - 1) step();
        chk("R8 restart by write", int'(to_irq), 0);
        step();
        chk("R8 fires after restart", int'(to_irq), 1);
        pop();
        repeat (tlim(0) - 1) step();
        chk("R8 restart by read", int'(to_irq), 0);
        step();
        chk("R8 fires after read", int'(to_irq), 1);
        for (int n = 0; n < 7; n++) push(20 + n, 0);
        step();
        chk("R8 cleared at threshold", int'(to_irq), 0);
        for (int n = 0; n < 8; n++) pop();

        // R12 no counting without ticks
        bit_tick = 1'b0;
        push(7, 0);
        repeat (100) step();
        chk("R12 paused", int'(to_irq), 0);
        bit_tick = 1'b1;
        repeat (tlim(0) - 1) step();
        chk("R12 one short", int'(to_irq), 0);
        step();
        chk("R12 fires after N ticks", int'(to_irq), 1);
        pop();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule